// File: doc/BRIEF.md
# Endpoint FIFO Access Controller

This block connects a small byte-wide CPU bus to four USB endpoint FIFOs. Firmware operates it through one command/status register that chooses an endpoint, sets the transfer direction, requests and releases access, flushes a FIFO and reports three status flags. Each endpoint also has its own data port on the bus, and payload bytes move through these ports. On the other side, the serial interface engine pushes and pops bytes over a plain FIFO interface. It also raises single-cycle events when a setup packet or a zero-length packet arrives.

Access is controlled by a five-state machine. In ST_IDLE no request is open. In ST_WAIT a request is pending, but the engine is still using the selected endpoint. ST_WRITE and ST_READ are the open transfer windows. In ST_CLOSE firmware has flipped the direction bit to end the transfer but has not yet dropped the request. The named transitions are as follows. T_REQ goes from ST_IDLE to ST_WAIT, ST_WRITE or ST_READ. T_GRANT goes from ST_WAIT to ST_WRITE or ST_READ once the engine is no longer busy on the endpoint. T_WR_END goes from ST_WRITE to ST_CLOSE when the direction bit falls. T_RD_END goes from ST_READ to ST_CLOSE when the direction bit rises. T_DROP goes from any state to ST_IDLE when the request bit is 0. T_URST goes from any state to ST_IDLE on USB reset. The state register updates one clock after the register write that causes the change.

Top module: `ep_fifo_bridge`

## Requirements
- R1: The command/status register sits at bus offset 0x46 and reads back as follows: bit0 request, bit1 direction (1 = firmware writes), bit2 flush (always reads 0), bits 4:3 endpoint select (00..11 = endpoint 0..3), bit5 setup flag, bit6 ready (read only), bit7 zero-length flag. After system reset it reads 0x00.
- R2: Writing request=1 with direction=1 opens a write window (ST_WRITE) when the engine is not busy on the selected endpoint. Ready reads 1 from the second clock after the write. Each bus write to data port 0x48+select then pushes one byte into that FIFO.
- R3: Clearing the direction bit while keeping request=1 ends a write window (ST_CLOSE). Ready reads 0, and later data-port writes push nothing.
- R4: Writing request=1 with direction=0 opens a read window (ST_READ). Each bus read of data port 0x48+select returns the oldest byte in the same cycle and pops it. A read of an empty FIFO returns 0x00.
- R5: Setting the direction bit while keeping request=1 ends a read window (ST_CLOSE), and ready reads 0.
- R6: While the engine reports the selected endpoint busy, a request waits in ST_WAIT with ready at 0. The window opens one clock after busy drops.
- R7: A data-port access outside an open window of the matching direction, or to a port other than the selected endpoint's, has no effect: the FIFO is unchanged and a read returns 0x00.
- R8: Writing the register with bit2=1 empties the endpoint named by bits 4:3 of that same write, in any state. The flush takes priority over an engine push to that endpoint in the same cycle.
- R9: The setup flag is set by the engine's setup event. Firmware clears it by writing 0 to bit5, and writing 1 to bit5 does not set it. If the event and the clearing write fall in the same cycle, the flag ends up set.
- R10: The zero-length flag follows the same rules as the setup flag, using bit7 and the engine's zero-length event.
- R11: USB reset clears the whole command/status register and returns the machine to ST_IDLE. Bytes already held in the FIFOs are kept.
- R12: Each endpoint FIFO holds DEPTH bytes in order. Empty and full are reported per endpoint, and an engine push into a full FIFO is dropped.
- R13: Writing request=0 returns the machine to ST_IDLE on the next clock from any state, and ready reads 0 after that.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| usb_reset | input | 1 | Synchronous USB bus reset |
| bus_addr | input | ADDR_W | CPU bus address |
| bus_wr | input | 1 | CPU bus write strobe |
| bus_rd | input | 1 | CPU bus read strobe |
| bus_wdata | input | 8 | CPU bus write data |
| bus_rdata | output | 8 | CPU bus read data, valid in the strobe cycle |
| sie_ep | input | 2 | Endpoint addressed by the engine |
| sie_push | input | 1 | Engine pushes sie_wdata into the FIFO of sie_ep |
| sie_wdata | input | 8 | Engine push data |
| sie_pop | input | 1 | Engine pops the FIFO of sie_ep |
| sie_rdata | output | 8 | Oldest byte of the FIFO of sie_ep |
| sie_busy | input | 4 | Engine is using the endpoint, one bit per endpoint |
| sie_setup | input | 1 | Setup packet event |
| sie_zlp | input | 1 | Zero-length packet event |
| ep_empty | output | 4 | FIFO empty, one bit per endpoint |
| ep_full | output | 4 | FIFO full, one bit per endpoint |

## Verification
Two pairs of actions can land in the same clock. In the first, firmware's write that clears the setup or zero-length flag meets the engine's event that sets it. The bench drives both in one cycle and then reads the register, expecting the flag to be set. In the second, a flush command meets an engine push to the same endpoint. The bench drives both together and expects that endpoint's empty output to be 1 afterwards. Randomized transfers of random length and direction around these directed cases keep the handshake and byte order under load.

// File: rtl/efc_pkg.sv
package efc_pkg;
    localparam int NUM_EP = 4;
    localparam int EP_W   = 2;
    localparam int DATA_W = 8;

    // command/status bit positions
    localparam int B_REQ    = 0;
    localparam int B_TX     = 1;
    localparam int B_CLR    = 2;
    localparam int B_SEL_LO = 3;
    localparam int B_SEL_HI = 4;
    localparam int B_SETUP  = 5;
    localparam int B_RDY    = 6;
    localparam int B_ZLP    = 7;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_WAIT  = 3'd1,
        ST_WRITE = 3'd2,
        ST_READ  = 3'd3,
        ST_CLOSE = 3'd4
    } xfer_state_t;
endpackage

// File: rtl/efc_ep_fifo.sv
module efc_ep_fifo #(
    parameter int DW    = 8,
    parameter int DEPTH = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          push,
    input  logic          pop,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout,
    output logic          empty,
    output logic          full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [CW-1:0] cnt;
    logic          do_push, do_pop;

    assign empty   = (cnt == '0);
    assign full    = (cnt == CW'(DEPTH));
    assign do_push = push && !full && !flush;
    assign do_pop  = pop && !empty && !flush;
    assign dout    = empty ? '0 : mem[rp];

    function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else if (flush) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_push) wp <= step(wp);
            if (do_pop)  rp <= step(rp);
            cnt <= cnt + CW'(do_push) - CW'(do_pop);
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= din;
    end
endmodule

// File: rtl/efc_csr.sv
module efc_csr
    import efc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              usb_reset,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    input  logic              setup_evt,
    input  logic              zlp_evt,
    output logic              req,
    output logic              tx,
    output logic [EP_W-1:0]   sel,
    output logic              setup_flag,
    output logic              zlp_flag,
    output logic              flush,
    output logic [EP_W-1:0]   flush_ep
);
    logic clr_setup, clr_zlp;

    assign clr_setup = wr_en && !wdata[B_SETUP];
    assign clr_zlp   = wr_en && !wdata[B_ZLP];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            {req, tx, sel, setup_flag, zlp_flag} <= '0;
        end else if (usb_reset) begin
            {req, tx, sel, setup_flag, zlp_flag} <= '0;
        end else begin
            if (wr_en) begin
                req <= wdata[B_REQ];
                tx  <= wdata[B_TX];
                sel <= wdata[B_SEL_HI:B_SEL_LO];
            end
            // event wins over a clearing write in the same cycle
            setup_flag <= setup_evt || (setup_flag && !clr_setup);
            zlp_flag   <= zlp_evt   || (zlp_flag   && !clr_zlp);
        end
    end

    assign flush    = wr_en && wdata[B_CLR] && !usb_reset;
    assign flush_ep = wdata[B_SEL_HI:B_SEL_LO];
endmodule

// File: rtl/efc_xfer_fsm.sv
module efc_xfer_fsm
    import efc_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        usb_reset,
    input  logic        req,
    input  logic        tx,
    input  logic        ep_busy,
    output xfer_state_t state,
    output logic        ready,
    output logic        wr_open,
    output logic        rd_open
);
    xfer_state_t nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         state <= ST_IDLE;
        else if (usb_reset) state <= ST_IDLE;
        else                state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE, ST_WAIT: begin
                if (!req)         nxt = ST_IDLE;
                else if (ep_busy) nxt = ST_WAIT;
                else if (tx)      nxt = ST_WRITE;
                else              nxt = ST_READ;
            end
            ST_WRITE: begin
                if (!req)     nxt = ST_IDLE;
                else if (!tx) nxt = ST_CLOSE;
            end
            ST_READ: begin
                if (!req)    nxt = ST_IDLE;
                else if (tx) nxt = ST_CLOSE;
            end
            ST_CLOSE: begin
                if (!req) nxt = ST_IDLE;
            end
            default: nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        wr_open = 1'b0;
        rd_open = 1'b0;
        unique case (state)
            ST_WRITE: wr_open = 1'b1;
            ST_READ:  rd_open = 1'b1;
            default: ;
        endcase
        ready = wr_open || rd_open;
    end
endmodule

// File: rtl/ep_fifo_bridge.sv
module ep_fifo_bridge
    import efc_pkg::*;
#(
    parameter int                ADDR_W    = 8,
    parameter int                DEPTH     = 8,
    parameter logic [ADDR_W-1:0] CSR_ADDR  = 'h46,
    parameter logic [ADDR_W-1:0] PORT_BASE = 'h48
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              usb_reset,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic [1:0]        sie_ep,
    input  logic              sie_push,
    input  logic [7:0]        sie_wdata,
    input  logic              sie_pop,
    output logic [7:0]        sie_rdata,
    input  logic [3:0]        sie_busy,
    input  logic              sie_setup,
    input  logic              sie_zlp,
    output logic [3:0]        ep_empty,
    output logic [3:0]        ep_full
);
    logic              csr_hit, port_hit, port_match;
    logic [ADDR_W-1:0] port_off;
    logic [EP_W-1:0]   port_ep;
    logic              csr_req, csr_tx, csr_setup, csr_zlp;
    logic [EP_W-1:0]   csr_sel, flush_ep;
    logic              flush;
    xfer_state_t       xfer_state;
    logic              xfer_ready, wr_open, rd_open;
    logic              fw_push, fw_pop;
    logic [DATA_W-1:0] fifo_dout [NUM_EP];
    logic [DATA_W-1:0] csr_rd_val;

    assign csr_hit    = (bus_addr == CSR_ADDR);
    assign port_off   = bus_addr - PORT_BASE;
    assign port_hit   = (port_off < ADDR_W'(NUM_EP));
    assign port_ep    = port_off[EP_W-1:0];
    assign port_match = port_hit && (port_ep == csr_sel);
    assign fw_push    = bus_wr && port_match && wr_open;
    assign fw_pop     = bus_rd && port_match && rd_open;

    efc_csr u_csr (
        .clk        (clk),
        .rst_n      (rst_n),
        .usb_reset  (usb_reset),
        .wr_en      (bus_wr && csr_hit),
        .wdata      (bus_wdata),
        .setup_evt  (sie_setup),
        .zlp_evt    (sie_zlp),
        .req        (csr_req),
        .tx         (csr_tx),
        .sel        (csr_sel),
        .setup_flag (csr_setup),
        .zlp_flag   (csr_zlp),
        .flush      (flush),
        .flush_ep   (flush_ep)
    );

    efc_xfer_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .usb_reset (usb_reset),
        .req       (csr_req),
        .tx        (csr_tx),
        .ep_busy   (sie_busy[csr_sel]),
        .state     (xfer_state),
        .ready     (xfer_ready),
        .wr_open   (wr_open),
        .rd_open   (rd_open)
    );

    for (genvar i = 0; i < NUM_EP; i++) begin : g_ep
        logic fw_here, sie_here;
        assign fw_here  = (csr_sel == EP_W'(i));
        assign sie_here = (sie_ep == EP_W'(i));

        efc_ep_fifo #(.DW(DATA_W), .DEPTH(DEPTH)) u_fifo (
            .clk   (clk),
            .rst_n (rst_n),
            .flush (flush && (flush_ep == EP_W'(i))),
            .push  ((fw_push && fw_here) || (sie_push && sie_here)),
            .pop   ((fw_pop && fw_here) || (sie_pop && sie_here)),
            .din   ((fw_push && fw_here) ? bus_wdata : sie_wdata),
            .dout  (fifo_dout[i]),
            .empty (ep_empty[i]),
            .full  (ep_full[i])
        );
    end

    assign csr_rd_val = {csr_zlp, xfer_ready, csr_setup, csr_sel, 1'b0, csr_tx, csr_req};

    always_comb begin
        if (bus_rd && csr_hit) bus_rdata = csr_rd_val;
        else if (fw_pop)       bus_rdata = fifo_dout[csr_sel];
        else                   bus_rdata = '0;
    end

    assign sie_rdata = fifo_dout[sie_ep];
endmodule

// File: rtl/ep_fifo_bridge_chk.sv
module ep_fifo_bridge_chk
    import efc_pkg::*;
#(
    parameter int                ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] CSR_ADDR = 'h46
) (
    input logic              clk,
    input logic              rst_n,
    input logic              usb_reset,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic [7:0]        bus_wdata,
    input logic              sie_setup,
    input logic              sie_push,
    input logic              sie_pop,
    input logic [1:0]        sie_ep,
    input logic [3:0]        ep_empty,
    input logic [3:0]        ep_full,
    input logic              csr_req,
    input logic              csr_setup,
    input logic              xfer_ready
);
    // R8
    flush_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == CSR_ADDR && bus_wdata[B_CLR] && !usb_reset)
        |=> ep_empty[$past(bus_wdata[B_SEL_HI:B_SEL_LO])]);

    // R9
    setup_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sie_setup && !usb_reset) |=> csr_setup);

    // R13
    req_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(csr_req) |=> !xfer_ready);

    // R11
    usb_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        usb_reset |=> (!csr_req && !xfer_ready && !csr_setup));

    // R12
    full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sie_push && ep_full[sie_ep] && !sie_pop && !bus_wr)
        |=> ep_full[$past(sie_ep)]);
endmodule

bind ep_fifo_bridge ep_fifo_bridge_chk #(.ADDR_W(ADDR_W), .CSR_ADDR(CSR_ADDR)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .usb_reset  (usb_reset),
    .bus_addr   (bus_addr),
    .bus_wr     (bus_wr),
    .bus_wdata  (bus_wdata),
    .sie_setup  (sie_setup),
    .sie_push   (sie_push),
    .sie_pop    (sie_pop),
    .sie_ep     (sie_ep),
    .ep_empty   (ep_empty),
    .ep_full    (ep_full),
    .csr_req    (csr_req),
    .csr_setup  (csr_setup),
    .xfer_ready (xfer_ready)
);

// File: tb/ep_fifo_bridge_tb.sv
module ep_fifo_bridge_tb_top;
    localparam int DEPTH = 8;
    localparam logic [7:0] CSR = 8'h46;
    localparam logic [7:0] PB  = 8'h48;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       usb_reset = 1'b0;
    logic [7:0] bus_addr = '0;
    logic       bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [1:0] sie_ep = '0;
    logic       sie_push = 1'b0, sie_pop = 1'b0;
    logic [7:0] sie_wdata = '0;
    logic [7:0] sie_rdata;
    logic [3:0] sie_busy = '0;
    logic       sie_setup = 1'b0, sie_zlp = 1'b0;
    logic [3:0] ep_empty, ep_full;

    int total = 0;
    int fails = 0;

    always #4 clk = ~clk;

    ep_fifo_bridge #(.DEPTH(DEPTH)) dut_i (.*);

    function automatic logic [7:0] exp_csr(input logic req, input logic tx, input logic [1:0] sel,
                                           input logic setup, input logic rdy, input logic zlp);
        return {zlp, rdy, setup, sel, 1'b0, tx, req};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk); bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk); bus_rd = 1'b1; bus_addr = a; #1 d = bus_rdata;
        @(negedge clk); bus_rd = 1'b0;
    endtask

    task automatic csr_set(input logic req, input logic tx, input logic [1:0] sel);
        bus_write(CSR, exp_csr(req, tx, sel, 1'b1, 1'b0, 1'b1)); // flag bits 1: keep flags
        @(negedge clk);
    endtask

    task automatic sie_put(input logic [1:0] ep, input logic [7:0] d);
        @(negedge clk); sie_push = 1'b1; sie_ep = ep; sie_wdata = d;
        @(negedge clk); sie_push = 1'b0;
    endtask

    task automatic sie_take(input logic [1:0] ep, output logic [7:0] d);
        @(negedge clk); sie_pop = 1'b1; sie_ep = ep; #1 d = sie_rdata;
        @(negedge clk); sie_pop = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++; total++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        logic [7:0] rd, exp_b [DEPTH];
        int unsigned sd;
        sd = $urandom(32'h5eed);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        bus_read(CSR, rd);
        chk("R1 reset csr", rd, 8'h00);
        chk("R12 reset empty", ep_empty, 4'hF);

        // R4 / R5 / R13: engine fills, firmware reads
        for (int k = 0; k < 20; k++) begin
            logic [1:0] ep = 2'($urandom);
            int n = 1 + int'($urandom % DEPTH);
            for (int j = 0; j < n; j++) begin
                exp_b[j] = 8'($urandom);
                sie_put(ep, exp_b[j]);
            end
            csr_set(1'b1, 1'b0, ep);
            bus_read(CSR, rd);
            chk("R4 read window ready", rd, exp_csr(1, 0, ep, 0, 1, 0));
            for (int j = 0; j < n; j++) begin
                bus_read(PB + 8'(ep), rd);
                chk("R4 pop order", rd, exp_b[j]);
            end
            bus_read(PB + 8'(ep), rd);
            chk("R4 empty read", rd, 8'h00);
            csr_set(1'b1, 1'b1, ep);
            bus_read(CSR, rd);
            chk("R5 read close", rd, exp_csr(1, 1, ep, 0, 0, 0));
            csr_set(1'b0, 1'b0, ep);
            bus_read(CSR, rd);
            chk("R13 idle", rd, exp_csr(0, 0, ep, 0, 0, 0));
        end

        // R2 / R3 / R7: firmware fills, engine drains
        for (int k = 0; k < 20; k++) begin
            logic [1:0] ep = 2'($urandom);
            logic [1:0] oth = ep ^ 2'd1;
            int n = 1 + int'($urandom % DEPTH);
            csr_set(1'b1, 1'b1, ep);
            bus_read(CSR, rd);
            chk("R2 write window ready", rd, exp_csr(1, 1, ep, 0, 1, 0));
            for (int j = 0; j < n; j++) begin
                exp_b[j] = 8'($urandom);
                bus_write(PB + 8'(ep), exp_b[j]);
            end
            bus_write(PB + 8'(oth), 8'hA5);
            chk("R7 other port ignored", ep_empty[oth], 1'b1);
            csr_set(1'b1, 1'b0, ep);
            bus_read(CSR, rd);
            chk("R3 write close", rd, exp_csr(1, 0, ep, 0, 0, 0));
            bus_write(PB + 8'(ep), 8'h5A);
            for (int j = 0; j < n; j++) begin
                sie_take(ep, rd);
                chk("R2 byte order", rd, exp_b[j]);
            end
            chk("R3 late write ignored", ep_empty[ep], 1'b1);
            csr_set(1'b0, 1'b0, ep);
        end

        // R6: busy endpoint holds the request
        sie_busy = 4'b0100;
        csr_set(1'b1, 1'b0, 2'd2);
        repeat (3) @(negedge clk);
        bus_read(CSR, rd);
        chk("R6 waiting", rd, exp_csr(1, 0, 2, 0, 0, 0));
        sie_busy = 4'b0000;
        bus_read(CSR, rd);
        chk("R6 granted", rd, exp_csr(1, 0, 2, 0, 1, 0));
        csr_set(1'b0, 1'b0, 2'd2);

        // R7: read outside window
        sie_put(2'd1, 8'h77);
        bus_read(PB + 8'd1, rd);
        chk("R7 idle read data", rd, 8'h00);
        chk("R7 idle read no pop", ep_empty[1], 1'b0);

        // R8: flush vs engine push same cycle, in idle
        sie_put(2'd3, 8'h11);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = CSR; bus_wdata = 8'h1C; // clear, sel 3
        sie_push = 1'b1; sie_ep = 2'd3; sie_wdata = 8'h22;
        @(negedge clk);
        bus_wr = 1'b0; sie_push = 1'b0;
        chk("R8 flush beats push", ep_empty[3], 1'b1);

        // R1: flush bit reads 0, fields read back
        bus_write(CSR, 8'h16);
        bus_read(CSR, rd);
        chk("R1 layout", rd, 8'h12);
        bus_write(CSR, 8'h00);

        // R9: setup event vs clearing write in same cycle
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = CSR; bus_wdata = 8'h00; sie_setup = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; sie_setup = 1'b0;
        bus_read(CSR, rd);
        chk("R9 set wins", rd, 8'h20);
        bus_write(CSR, 8'h00);
        bus_read(CSR, rd);
        chk("R9 cleared", rd, 8'h00);
        bus_write(CSR, 8'h20);
        bus_read(CSR, rd);
        chk("R9 write one no set", rd, 8'h00);

        // R10: zero-length flag
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = CSR; bus_wdata = 8'h00; sie_zlp = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; sie_zlp = 1'b0;
        bus_read(CSR, rd);
        chk("R10 set wins", rd, 8'h80);
        bus_write(CSR, 8'h00);
        bus_read(CSR, rd);
        chk("R10 cleared", rd, 8'h00);
        bus_write(CSR, 8'h80);
        bus_read(CSR, rd);
        chk("R10 write one no set", rd, 8'h00);

        // R11: USB reset clears register, keeps FIFO data (ep1 still holds 0x77)
        @(negedge clk); sie_setup = 1'b1;
        @(negedge clk); sie_setup = 1'b0;
        csr_set(1'b1, 1'b0, 2'd1);
        @(negedge clk); usb_reset = 1'b1;
        @(negedge clk); usb_reset = 1'b0;
        bus_read(CSR, rd);
        chk("R11 csr cleared", rd, 8'h00);
        chk("R11 fifo kept", ep_empty[1], 1'b0);

        // R12: full FIFO drops engine push
        for (int j = 0; j < DEPTH - 1; j++) sie_put(2'd1, 8'(j));
        chk("R12 full", ep_full[1], 1'b1);
        sie_put(2'd1, 8'hEE);
        sie_take(2'd1, rd);
        chk("R12 head kept", rd, 8'h77);
        for (int j = 0; j < DEPTH - 1; j++) begin
            sie_take(2'd1, rd);
            chk("R12 order", rd, 8'(j));
        end
        chk("R12 overflow dropped", ep_empty[1], 1'b1);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule